// File: doc/BRIEF.md
# Channel Fill Threshold Monitor

This block sits beside a multi-channel FIFO and watches how full each channel's segment is. The FIFO logic supplies every channel's fill level on one flat input bus. The monitor keeps a single upper threshold and a single lower threshold, and every channel shares them. Software sets both thresholds through a small memory-mapped control port.

A second memory-mapped port returns the fill level of the channel named by its address. Its read latency is one cycle. A streaming status output visits the channels in a fixed rotation, one channel per clock. On each clock it presents a channel number, an almost-full flag and an almost-empty flag, so a downstream consumer can track every channel over a few cycles without a wide parallel bus.

The channel count is a parameter and may be 1, 2, 4, 8 or 16. The segment depth sets the width of the fill levels and of the thresholds.

Top module: `chan_level_watch`

## Requirements
- R1: While reset is held low, and right after it, the upper (almost-full) threshold equals DEPTH-1 and the lower (almost-empty) threshold equals 0. While reset is low, st_valid, ctl_rvalid and lvl_rvalid are low.
- R2: A control write with ctl_addr=0 loads the upper threshold and a write with ctl_addr=1 loads the lower threshold. Only the low LVL_W bits of ctl_wdata are kept. Reads return the stored value with zeros above bit LVL_W-1. A threshold changes on no other cycle.
- R3: A control read returns its data on ctl_rdata with ctl_rvalid high in the cycle after the request. ctl_rvalid is low in any cycle that does not follow a read request.
- R4: A fill-level read returns the level of channel lvl_addr on lvl_rdata, zero-extended, with lvl_rvalid high in the next cycle. The level is the value sampled at the request edge. Channel k sits at bits [k*LVL_W +: LVL_W] of fill_levels. lvl_rvalid is low in a cycle that does not follow a request.
- R5: st_channel is 0 in the first cycle after reset. It then advances by one every clock and wraps from NUM_CH-1 back to 0.
- R6: st_valid goes high at the first clock edge after reset and stays high on every cycle until the next reset.
- R7: st_almost_full is high exactly when the reported channel's level is greater than or equal to the upper threshold. The level is sampled at the same edge that produces the output.
- R8: st_almost_empty is high exactly when the reported channel's level is less than or equal to the lower threshold.
- R9: A threshold write takes effect for every channel. All status produced at edges after the write edge uses the new value.
- R10: When a read and a write to the same control offset happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_addr | input | 1 | Control word offset (0 upper threshold, 1 lower threshold) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rd | input | 1 | Control read strobe |
| ctl_wdata | input | CSR_W | Control write data |
| ctl_rdata | output | CSR_W | Control read data |
| ctl_rvalid | output | 1 | Control read data valid |
| lvl_addr | input | CH_W | Channel to read the level of |
| lvl_rd | input | 1 | Fill-level read strobe |
| lvl_rdata | output | CSR_W | Fill-level read data |
| lvl_rvalid | output | 1 | Fill-level read data valid |
| fill_levels | input | NUM_CH*LVL_W | Per-channel fill levels, channel k at [k*LVL_W +: LVL_W] |
| st_valid | output | 1 | Status strobe |
| st_channel | output | CH_W | Channel the status refers to |
| st_almost_full | output | 1 | Level at or above the upper threshold |
| st_almost_empty | output | 1 | Level at or below the lower threshold |

## Verification
The bench drives levels that sit exactly on each threshold, so that a strict comparison instead of an inclusive one drops a flag on the boundary channel. It writes data with bits set above the threshold width; a design that kept them would read back a large value. It also writes with the upper threshold at 0 and the lower threshold at full depth, where every channel must raise both flags.

The bench changes a fill level in the cycle after a level read, which exposes a design that samples late. It issues a read and a write to the same offset in one cycle, which catches forwarding of the new value. Throughout, it follows the rotation across several wraps, so a counter that skips, stalls or wraps at the wrong count shows up as a channel mismatch.

// File: rtl/lvlw_pkg.sv
package lvlw_pkg;

   // Control register offsets; the bit value is the decoded address
   typedef enum logic {
      THR_UPPER = 1'b0,
      THR_LOWER = 1'b1
   } thr_sel_e;

   function automatic bit legal_chan_count(input int n);
      return (n == 1) || (n == 2) || (n == 4) || (n == 8) || (n == 16);
   endfunction

   function automatic int chan_idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lvlw_thresh_regs.sv
module lvlw_thresh_regs
   import lvlw_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5,
   parameter int CSR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic             addr,
   input  logic [CSR_W-1:0] wdata,
   output logic [CSR_W-1:0] rdata,
   output logic             rvalid,
   output logic [LVL_W-1:0] upper_thr,
   output logic [LVL_W-1:0] lower_thr
);

   localparam logic [LVL_W-1:0] UPPER_INIT = LVL_W'(DEPTH - 1);
   localparam logic [LVL_W-1:0] LOWER_INIT = '0;

   logic [LVL_W-1:0] upper_q, lower_q;
   logic             unused_wdata_bits;
   thr_sel_e         sel;

   assign sel               = thr_sel_e'(addr);
   assign unused_wdata_bits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= UPPER_INIT;
         lower_q <= LOWER_INIT;
      end else if (wr) begin
         if (sel == THR_UPPER) upper_q <= wdata[LVL_W-1:0];
         else                  lower_q <= wdata[LVL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd;
         if (rd) rdata <= (sel == THR_UPPER) ? CSR_W'(upper_q) : CSR_W'(lower_q);
      end
   end

   assign upper_thr = upper_q;
   assign lower_thr = lower_q;

   // R2
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(upper_q) && $stable(lower_q)));

   // R3
   ctl_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rvalid);

   // R3
   ctl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rvalid);

endmodule

// File: rtl/lvlw_level_port.sv
module lvlw_level_port
   import lvlw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int LVL_W  = 5,
   parameter int CSR_W  = 32,
   parameter int CH_W   = chan_idx_width(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] lvls [NUM_CH],
   input  logic             rd,
   input  logic [CH_W-1:0]  addr,
   output logic [CSR_W-1:0] rdata,
   output logic             rvalid
);

   logic [LVL_W-1:0] picked;

   generate
      if (NUM_CH == 1) begin : g_single
         logic unused_addr;
         assign unused_addr = ^addr;
         assign picked      = lvls[0];
      end else begin : g_multi
         assign picked = lvls[addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd;
         if (rd) rdata <= CSR_W'(picked);
      end
   end

   // R4
   lvl_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rvalid);

   // R4
   lvl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rvalid);

endmodule

// File: rtl/lvlw_status_scan.sv
module lvlw_status_scan
   import lvlw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int LVL_W  = 5,
   parameter int CH_W   = chan_idx_width(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] lvls [NUM_CH],
   input  logic [LVL_W-1:0] upper_thr,
   input  logic [LVL_W-1:0] lower_thr,
   output logic             st_valid,
   output logic [CH_W-1:0]  st_channel,
   output logic             st_almost_full,
   output logic             st_almost_empty
);

   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   logic [CH_W-1:0]  scan_q;
   logic [LVL_W-1:0] cur_lvl;

   generate
      if (NUM_CH == 1) begin : g_fixed
         assign scan_q  = '0;
         assign cur_lvl = lvls[0];
      end else begin : g_rotate
         logic [CH_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (cnt_q == LAST_CH)  cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
         end
         assign scan_q  = cnt_q;
         assign cur_lvl = lvls[cnt_q];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_valid        <= 1'b0;
         st_channel      <= '0;
         st_almost_full  <= 1'b0;
         st_almost_empty <= 1'b0;
      end else begin
         st_valid        <= 1'b1;
         st_channel      <= scan_q;
         st_almost_full  <= (cur_lvl >= upper_thr);
         st_almost_empty <= (cur_lvl <= lower_thr);
      end
   end

   // R6
   st_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> st_valid);

   // R5
   st_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && $past(st_valid)) |->
         (st_channel == (($past(st_channel) == LAST_CH) ? '0 : $past(st_channel) + 1'b1)));

   // R7
   both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_almost_full && st_almost_empty) |-> ($past(upper_thr) <= $past(lower_thr)));

endmodule

// File: rtl/chan_level_watch.sv
module chan_level_watch
   import lvlw_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DEPTH  = 16,
   parameter int CSR_W  = 32,
   parameter int LVL_W  = $clog2(DEPTH + 1),
   parameter int CH_W   = chan_idx_width(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_addr,
   input  logic                    ctl_wr,
   input  logic                    ctl_rd,
   input  logic [CSR_W-1:0]        ctl_wdata,
   output logic [CSR_W-1:0]        ctl_rdata,
   output logic                    ctl_rvalid,
   input  logic [CH_W-1:0]         lvl_addr,
   input  logic                    lvl_rd,
   output logic [CSR_W-1:0]        lvl_rdata,
   output logic                    lvl_rvalid,
   input  logic [NUM_CH*LVL_W-1:0] fill_levels,
   output logic                    st_valid,
   output logic [CH_W-1:0]         st_channel,
   output logic                    st_almost_full,
   output logic                    st_almost_empty
);

   generate
      if (!legal_chan_count(NUM_CH)) begin : g_bad_ch
         $error("chan_level_watch: NUM_CH must be 1, 2, 4, 8 or 16");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("chan_level_watch: DEPTH must be at least 2");
      end
      if (CSR_W < LVL_W) begin : g_bad_csr
         $error("chan_level_watch: CSR_W narrower than a fill level");
      end
   endgenerate

   logic [LVL_W-1:0] lvls [NUM_CH];
   logic [LVL_W-1:0] upper_thr, lower_thr;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
         assign lvls[k] = fill_levels[k*LVL_W +: LVL_W];
      end
   endgenerate

   lvlw_thresh_regs #(
      .DEPTH (DEPTH),
      .LVL_W (LVL_W),
      .CSR_W (CSR_W)
   ) thr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .rd        (ctl_rd),
      .addr      (ctl_addr),
      .wdata     (ctl_wdata),
      .rdata     (ctl_rdata),
      .rvalid    (ctl_rvalid),
      .upper_thr (upper_thr),
      .lower_thr (lower_thr)
   );

   lvlw_level_port #(
      .NUM_CH (NUM_CH),
      .LVL_W  (LVL_W),
      .CSR_W  (CSR_W),
      .CH_W   (CH_W)
   ) lvl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvls   (lvls),
      .rd     (lvl_rd),
      .addr   (lvl_addr),
      .rdata  (lvl_rdata),
      .rvalid (lvl_rvalid)
   );

   lvlw_status_scan #(
      .NUM_CH (NUM_CH),
      .LVL_W  (LVL_W),
      .CH_W   (CH_W)
   ) scan_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .lvls            (lvls),
      .upper_thr       (upper_thr),
      .lower_thr       (lower_thr),
      .st_valid        (st_valid),
      .st_channel      (st_channel),
      .st_almost_full  (st_almost_full),
      .st_almost_empty (st_almost_empty)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!st_valid && !ctl_rvalid && !lvl_rvalid));

endmodule

// File: tb/chan_level_watch_tb_top.sv
module chan_level_watch_tb_top;

   localparam int NCH   = 4;
   localparam int DEP   = 16;
   localparam int CW    = 32;
   localparam int LW    = $clog2(DEP + 1);
   localparam int CHW   = $clog2(NCH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_addr = 1'b0;
   logic             ctl_wr = 1'b0;
   logic             ctl_rd = 1'b0;
   logic [CW-1:0]    ctl_wdata = '0;
   logic [CW-1:0]    ctl_rdata;
   logic             ctl_rvalid;
   logic [CHW-1:0]   lvl_addr = '0;
   logic             lvl_rd = 1'b0;
   logic [CW-1:0]    lvl_rdata;
   logic             lvl_rvalid;
   logic [NCH*LW-1:0] fill_levels;
   logic             st_valid;
   logic [CHW-1:0]   st_channel;
   logic             st_almost_full;
   logic             st_almost_empty;

   int fill_m [NCH];
   int upper_m;
   int lower_m;
   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NCH; k++) fill_levels[k*LW +: LW] = LW'(fill_m[k]);
   end

   chan_level_watch #(.NUM_CH(NCH), .DEPTH(DEP), .CSR_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid),
      .lvl_addr(lvl_addr), .lvl_rd(lvl_rd), .lvl_rdata(lvl_rdata), .lvl_rvalid(lvl_rvalid),
      .fill_levels(fill_levels),
      .st_valid(st_valid), .st_channel(st_channel),
      .st_almost_full(st_almost_full), .st_almost_empty(st_almost_empty)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ctl_write(input logic a, input logic [CW-1:0] d);
      @(negedge clk);
      ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      if (a == 1'b0) upper_m = int'(d[LW-1:0]);
      else           lower_m = int'(d[LW-1:0]);
   endtask

   task automatic ctl_read(input logic a, input int exp, input string tag);
      @(negedge clk);
      ctl_addr = a; ctl_rd = 1'b1;
      @(negedge clk);
      ctl_rd = 1'b0;
      check({tag, " R3 rvalid"}, ctl_rvalid, 1);
      check({tag, " rdata"}, ctl_rdata, exp);
      @(negedge clk);
      check("R3 rvalid drops", ctl_rvalid, 0);
   endtask

   task automatic scan_check(input int cycles, input string tag);
      int prev = -1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check({tag, " R6 st_valid"}, st_valid, 1);
         if (prev >= 0) check({tag, " R5 step"}, st_channel, (prev + 1) % NCH);
         prev = int'(st_channel);
         check({tag, " R7 almost_full"}, st_almost_full, fill_m[prev] >= upper_m);
         check({tag, " R8 almost_empty"}, st_almost_empty, fill_m[prev] <= lower_m);
      end
   endtask

   task automatic t_reset;
      for (int k = 0; k < NCH; k++) fill_m[k] = 5;
      upper_m = DEP - 1; lower_m = 0;
      repeat (3) @(negedge clk);
      check("R1 st_valid in reset", st_valid, 0);
      check("R1 ctl_rvalid in reset", ctl_rvalid, 0);
      check("R1 lvl_rvalid in reset", lvl_rvalid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 st_valid first", st_valid, 1);
      check("R5 first channel", st_channel, 0);
      ctl_read(1'b0, DEP - 1, "R1 upper init");
      ctl_read(1'b1, 0, "R1 lower init");
   endtask

   task automatic t_thresh_rw;
      ctl_write(1'b0, 32'hFFFF_FF0A);
      ctl_read(1'b0, 10, "R2 upper trunc");
      ctl_write(1'b1, 32'h0000_0123);
      ctl_read(1'b1, 3, "R2 lower trunc");
      ctl_read(1'b0, 10, "R2 upper kept");
   endtask

   task automatic t_collide;
      @(negedge clk);
      ctl_addr = 1'b0; ctl_wdata = 32'd7; ctl_wr = 1'b1; ctl_rd = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_rd = 1'b0;
      check("R10 collide rvalid", ctl_rvalid, 1);
      check("R10 collide old value", ctl_rdata, 10);
      upper_m = 7;
      ctl_read(1'b0, 7, "R10 new value after");
   endtask

   task automatic t_level_read;
      fill_m[0] = 3; fill_m[1] = 16; fill_m[2] = 0; fill_m[3] = 9;
      for (int c = 0; c < NCH; c++) begin
         int old = fill_m[c];
         @(negedge clk);
         lvl_addr = CHW'(c); lvl_rd = 1'b1;
         @(negedge clk);
         lvl_rd = 1'b0;
         fill_m[c] = old + 1;
         check("R4 lvl_rvalid", lvl_rvalid, 1);
         check("R4 level sampled at request", lvl_rdata, old);
         @(negedge clk);
         check("R4 lvl_rvalid drops", lvl_rvalid, 0);
         fill_m[c] = old;
      end
   endtask

   task automatic t_scan;
      ctl_write(1'b0, 32'd9);
      ctl_write(1'b1, 32'd3);
      fill_m[0] = 9; fill_m[1] = 8; fill_m[2] = 3; fill_m[3] = 4;
      @(negedge clk);
      scan_check(3 * NCH + 1, "boundary");
   endtask

   task automatic t_shared;
      ctl_write(1'b0, 32'd4);
      scan_check(2 * NCH + 2, "R9 shared upper");
      ctl_write(1'b0, 32'd0);
      ctl_write(1'b1, 32'd16);
      scan_check(2 * NCH, "R9 extremes");
      fill_m[0] = 0; fill_m[1] = 16; fill_m[2] = 1; fill_m[3] = 15;
      @(negedge clk);
      scan_check(NCH + 1, "R7 R8 full range");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_thresh_rw();
            t_collide();
            t_level_read();
            t_scan();
            t_shared();
         end
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule